// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Queue

This block is the receive half of an asynchronous serial port. It watches a single RX line, qualifies start bits, recovers each bit from sixteen samples per bit period by a three-sample majority vote, and assembles characters in one of four frame formats. Each finished character goes into a small receive queue together with two flags of its own: one for a parity mismatch and one for a bad stop bit. Software reads the queue through a head-of-queue view. A one-cycle read strobe drops the head entry, and the next character then appears with its own flags.

A sample-rate strobe from outside paces the receiver at sixteen pulses per bit. The block raises an interrupt request when the queue holds enough characters for the selected level. A sticky overrun flag records that a character was lost because the queue was full. While that flag is set, reception is frozen, and it stays set until the clear input is pulsed. An idle output shows whether a frame is in progress.

Top module: `serial_rx_fifo`

## Requirements
- R1: `frameMode` picks the frame. 0 is 8 data bits. 1 is 8 data bits plus an even parity bit. 2 is 8 data bits plus an odd parity bit. 3 is 9 data bits. Data bits arrive LSB first. In the 8-bit formats `rdData[8]` reads 0.
- R2: A low level on the line starts a frame only if the line is still low at sample 8 of the start bit. Otherwise the receiver returns to idle and stores nothing.
- R3: Each data, parity and stop bit takes the majority value of samples 7, 8 and 9 of its bit, counted from 0. A disturbance that reaches only one of those samples does not change the received value.
- R4: `rdParErr` of an entry is 1 when that character's received parity bit does not match its format. It is always 0 in formats 0 and 3.
- R5: `rdFrmErr` of an entry is 1 when the stop bit was received low. Such a character is still stored.
- R6: The queue holds 4 entries in arrival order, and `charCount` gives the fill level. `rdValid` is high when the queue is not empty. A `popReq` pulse removes the head entry, and the next entry is visible one cycle later with its own flags. A `popReq` on an empty queue changes nothing.
- R7: A character that completes while the queue is full is dropped and sets `overrun`. The stored entries are kept. `overrun` stays high until an `ovrClear` pulse.
- R8: While `overrun` is high, every completed character is dropped even when the queue has room.
- R9: `irq` follows `irqSel`. Select 0 gives at least 1 entry, select 1 gives at least 3 entries, and selects 2 and 3 give a full queue. `irq` is low whenever the queue is empty.
- R10: `idle` is high when no frame is in progress. It is low from start detection until the stop-bit decision.
- R11: After reset the queue is empty, and `overrun` and `irq` are low while `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxLine | input | 1 | Serial input line, idle high |
| frameMode | input | 2 | Frame format select, captured at start detection |
| irqSel | input | 2 | Interrupt fill-level select |
| popReq | input | 1 | Remove the head entry |
| ovrClear | input | 1 | Clear the overrun flag |
| rdData | output | 9 | Head character |
| rdParErr | output | 1 | Parity error flag of the head character |
| rdFrmErr | output | 1 | Framing error flag of the head character |
| rdValid | output | 1 | Queue not empty |
| charCount | output | 3 | Number of stored characters |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt request |
| idle | output | 1 | No frame in progress |

## Verification
The line passes through a two-flop synchronizer. A character is therefore pushed on the clock edge at sample 9 of its stop bit, a few clocks after the line value that decides it, and `charCount`, `rdValid` and `irq` change in the cycle after that push. The bench drives each frame bit for one full bit period and then holds the line idle for two more bit periods before it samples, so every queue result has settled long before it is read. A pop takes effect at the next rising edge. The bench raises `popReq` on a falling edge, lowers it one clock later and reads the new head on the falling edge that follows. The idle flag is checked in the middle of the first data bit, well inside the frame.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int CHAR_W = 9;

  typedef enum logic [1:0] {
    FMT_8N = 2'd0,
    FMT_8E = 2'd1,
    FMT_8O = 2'd2,
    FMT_9N = 2'd3
  } rxFormat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic capA;      // take first vote sample
    logic capB;      // take second vote sample
    logic shiftIn;   // vote complete, shift data bit
    logic parityIn;  // vote complete, latch parity bit
    logic stopIn;    // vote complete on stop bit, push character
  } rxStrobe_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              parErr;
    logic              frmErr;
  } rxEntry_t;

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineNow,
  input  logic [1:0] frameMode,
  output rxStrobe_t stb,
  output rxFormat_t fmtQ,
  output logic      idle
);

  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;
  localparam logic [CW-1:0] LAST_C = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] EARLY_C = CW'(HALF - 1);
  localparam logic [CW-1:0] LATE_C = CW'(HALF + 1);

  rxState_t    state;
  logic [CW-1:0] smpCnt;
  logic [3:0]  bitCnt;
  logic [3:0]  lastBit;
  logic        hasParity;
  logic        voteState;

  assign lastBit   = (fmtQ == FMT_9N) ? 4'd8 : 4'd7;
  assign hasParity = (fmtQ == FMT_8E) || (fmtQ == FMT_8O);
  assign voteState = (state == ST_DATA) || (state == ST_PAR) || (state == ST_STOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
      bitCnt <= '0;
      fmtQ   <= FMT_8N;
    end else if (sampleTick) begin
      smpCnt <= smpCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          smpCnt <= '0;
          if (!lineNow) begin
            state <= ST_START;
            fmtQ  <= rxFormat_t'(frameMode);
          end
        end
        ST_START: begin
          if (smpCnt == HALF_C && lineNow) begin
            state <= ST_IDLE;
          end else if (smpCnt == LAST_C) begin
            state  <= ST_DATA;
            smpCnt <= '0;
            bitCnt <= '0;
          end
        end
        ST_DATA: begin
          if (smpCnt == LAST_C) begin
            smpCnt <= '0;
            if (bitCnt == lastBit) begin
              state <= hasParity ? ST_PAR : ST_STOP;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (smpCnt == LAST_C) begin
            smpCnt <= '0;
            state  <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (smpCnt == LATE_C) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.capA     = sampleTick && voteState && (smpCnt == EARLY_C);
    stb.capB     = sampleTick && voteState && (smpCnt == HALF_C);
    stb.shiftIn  = sampleTick && (state == ST_DATA) && (smpCnt == LATE_C);
    stb.parityIn = sampleTick && (state == ST_PAR)  && (smpCnt == LATE_C);
    stb.stopIn   = sampleTick && (state == ST_STOP) && (smpCnt == LATE_C);
  end

  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxLine,
  input  rxStrobe_t stb,
  input  rxFormat_t fmtQ,
  output logic      lineNow,
  output logic      pushEn,
  output rxEntry_t  pushEntry
);

  logic [1:0]        syncQ;
  logic              smpA;
  logic              smpB;
  logic              vote;
  logic [CHAR_W-1:0] shiftQ;
  logic              parQ;
  logic [CHAR_W-1:0] charVal;
  logic              parOnes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end
  assign lineNow = syncQ[1];

  // majority of two held samples and the present one
  assign vote = (smpA & smpB) | (smpA & lineNow) | (smpB & lineNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smpA   <= 1'b1;
      smpB   <= 1'b1;
      shiftQ <= '0;
      parQ   <= 1'b0;
    end else begin
      if (stb.capA)     smpA   <= lineNow;
      if (stb.capB)     smpB   <= lineNow;
      if (stb.shiftIn)  shiftQ <= {vote, shiftQ[CHAR_W-1:1]};
      if (stb.parityIn) parQ   <= vote;
    end
  end

  assign charVal = (fmtQ == FMT_9N) ? shiftQ : {1'b0, shiftQ[CHAR_W-1:1]};
  assign parOnes = ^{charVal[7:0], parQ};

  always_comb begin
    pushEntry.data   = charVal;
    pushEntry.frmErr = !vote;
    unique case (fmtQ)
      FMT_8E:  pushEntry.parErr = parOnes;
      FMT_8O:  pushEntry.parErr = !parOnes;
      default: pushEntry.parErr = 1'b0;
    endcase
  end

  assign pushEn = stb.stopIn;

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int MID_LEVEL = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pushEn,
  input  rxEntry_t                     pushEntry,
  input  logic                         popReq,
  input  logic                         ovrClear,
  input  logic [1:0]                   irqSel,
  output rxEntry_t                     head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         overrun,
  output logic                         irq
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] MID_C  = CW'(MID_LEVEL);
  localparam logic [PW-1:0] LASTP  = PW'(DEPTH - 1);

  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic          full;
  logic          accept;
  logic          lost;
  logic          doPop;
  rxEntry_t      slotQ [DEPTH];

  assign full   = (count == FULL_C);
  assign accept = pushEn && !overrun && !full;
  assign lost   = pushEn && !overrun && full;
  assign doPop  = popReq && (count != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    rxEntry_t q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 q <= '0;
      else if (accept && wrPtr == PW'(i))        q <= pushEntry;
    end
    assign slotQ[i] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept) wrPtr <= (wrPtr == LASTP) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LASTP) ? '0 : rdPtr + 1'b1;
      unique case ({accept, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (lost)          overrun <= 1'b1;
      else if (ovrClear) overrun <= 1'b0;
    end
  end

  assign head = slotQ[rdPtr];

  always_comb begin
    unique case (irqSel)
      2'd0:    irq = (count != '0);
      2'd1:    irq = (count >= MID_C) && (count != '0);
      default: irq = full;
    endcase
  end

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int MID_LEVEL  = 3,
  parameter int OVERSAMPLE = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleTick,
  input  logic                       rxLine,
  input  logic [1:0]                 frameMode,
  input  logic [1:0]                 irqSel,
  input  logic                       popReq,
  input  logic                       ovrClear,
  output logic [CHAR_W-1:0]          rdData,
  output logic                       rdParErr,
  output logic                       rdFrmErr,
  output logic                       rdValid,
  output logic [$clog2(DEPTH+1)-1:0] charCount,
  output logic                       overrun,
  output logic                       irq,
  output logic                       idle
);

  rxStrobe_t stb;
  rxFormat_t fmtQ;
  logic      lineNow;
  logic      pushEn;
  rxEntry_t  pushEntry;
  rxEntry_t  head;

  srx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) uCtrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .lineNow(lineNow),
    .frameMode(frameMode), .stb(stb), .fmtQ(fmtQ), .idle(idle)
  );

  srx_datapath uPath (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .stb(stb), .fmtQ(fmtQ),
    .lineNow(lineNow), .pushEn(pushEn), .pushEntry(pushEntry)
  );

  srx_fifo #(.DEPTH(DEPTH), .MID_LEVEL(MID_LEVEL)) uFifo (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushEntry(pushEntry),
    .popReq(popReq), .ovrClear(ovrClear), .irqSel(irqSel), .head(head),
    .count(charCount), .overrun(overrun), .irq(irq)
  );

  assign rdData   = head.data;
  assign rdParErr = head.parErr;
  assign rdFrmErr = head.frmErr;
  assign rdValid  = (charCount != '0);

endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       popReq,
  input logic                       ovrClear,
  input logic                       overrun,
  input logic [$clog2(DEPTH+1)-1:0] charCount,
  input logic                       irq,
  input logic                       idle
);

  // R7: overrun holds until cleared
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !ovrClear |=> overrun);

  // R6: fill level never passes the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    charCount <= ($clog2(DEPTH+1))'(DEPTH));

  // R8: no entry is added while overrun is set
  a_r8_frozen_while_overrun: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !popReq |=> charCount == $past(charCount));

  // R9: no request without data
  a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    charCount == '0 |-> !irq);

  // R10: idle is always a defined level
  a_r10_idle_known: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(idle));

endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .popReq(popReq), .ovrClear(ovrClear),
  .overrun(overrun), .charCount(charCount), .irq(irq), .idle(idle)
);

// File: tb/serial_rx_fifo_test.sv
`timescale 1ns/1ps
module serial_rx_fifo_test;

  localparam int BITCLK = 64;   // 16 ticks of 4 clocks
  localparam int NVEC   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] frameMode = 2'd0;
  logic [1:0] irqSel = 2'd0;
  logic       popReq = 1'b0;
  logic       ovrClear = 1'b0;
  logic [8:0] rdData;
  logic       rdParErr, rdFrmErr, rdValid, overrun, irq, idle;
  logic [2:0] charCount;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  serial_rx_fifo uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .frameMode(frameMode), .irqSel(irqSel), .popReq(popReq), .ovrClear(ovrClear),
    .rdData(rdData), .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdValid(rdValid),
    .charCount(charCount), .overrun(overrun), .irq(irq), .idle(idle)
  );

  always #2.5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sampleTick = 1'b1;
      @(negedge clk);
      sampleTick = 1'b0;
    end
  end

  // {mode[1:0], flipParity, stopLevel, payload[8:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b1, 9'h0A5},
    {2'd0, 1'b0, 1'b0, 9'h03C},
    {2'd1, 1'b0, 1'b1, 9'h07E},
    {2'd1, 1'b1, 1'b1, 9'h081},
    {2'd2, 1'b0, 1'b1, 9'h055},
    {2'd2, 1'b1, 1'b0, 9'h0FF},
    {2'd3, 1'b0, 1'b1, 9'h1C3},
    {2'd3, 1'b0, 1'b0, 9'h100}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] expData(input logic [1:0] m, input logic [8:0] p);
    return (m == 2'd3) ? p : {1'b0, p[7:0]};
  endfunction

  function automatic logic expPar(input logic [1:0] m, input logic flip);
    return ((m == 2'd1) || (m == 2'd2)) ? flip : 1'b0;
  endfunction

  task automatic holdBit(input logic v);
    rxLine = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  // glitchBit: index of a data bit that gets a one-sample disturbance at mid-bit
  task automatic sendFrame(input logic [1:0] m, input logic [8:0] p, input logic flip,
                           input logic stopV, input int glitchBit, input bit idleChk);
    int nb;
    logic pb;
    nb = (m == 2'd3) ? 9 : 8;
    pb = (m == 2'd1) ? ^p[7:0] : ~^p[7:0];
    frameMode = m;
    holdBit(1'b0);
    if (idleChk) begin
      repeat (32) @(negedge clk);
      check(idle == 1'b0, "R10", "idle mid-frame", idle, 0);
      rxLine = p[0];
      repeat (BITCLK - 32) @(negedge clk);
    end else begin
      rxLine = p[0];
      if (glitchBit == 0) begin
        repeat (32) @(negedge clk); rxLine = ~p[0];
        repeat (4) @(negedge clk);  rxLine = p[0];
        repeat (BITCLK - 36) @(negedge clk);
      end else begin
        repeat (BITCLK) @(negedge clk);
      end
    end
    for (int i = 1; i < nb; i++) begin
      rxLine = p[i];
      if (glitchBit == i) begin
        repeat (32) @(negedge clk); rxLine = ~p[i];
        repeat (4) @(negedge clk);  rxLine = p[i];
        repeat (BITCLK - 36) @(negedge clk);
      end else begin
        repeat (BITCLK) @(negedge clk);
      end
    end
    if ((m == 2'd1) || (m == 2'd2)) holdBit(pb ^ flip);
    holdBit(stopV);
    holdBit(1'b1);
    holdBit(1'b1);
  endtask

  task automatic pop();
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkHead(input string req, input logic [8:0] d, input logic pe, input logic fe);
    check(rdValid == 1'b1, req, "rdValid", rdValid, 1);
    check(rdData == d, req, "rdData", rdData, d);
    check(rdParErr == pe, req, "rdParErr", rdParErr, pe);
    check(rdFrmErr == fe, req, "rdFrmErr", rdFrmErr, fe);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    check(charCount == 0, "R11", "charCount", charCount, 0);
    check(rdValid == 0, "R11", "rdValid", rdValid, 0);
    check(overrun == 0, "R11", "overrun", overrun, 0);
    check(irq == 0, "R11", "irq", irq, 0);
    check(idle == 1, "R11", "idle", idle, 1);

    // R1 R4 R5: table of formats and error flags
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] m;
      logic fl, sv;
      logic [8:0] p;
      {m, fl, sv, p} = VEC[k];
      sendFrame(m, p, fl, sv, -1, 1'b0);
      check(charCount == 1, "R6", "count after frame", charCount, 1);
      checkHead("R1", expData(m, p), expPar(m, fl), !sv);
      pop();
      check(rdValid == 0, "R6", "empty after pop", rdValid, 0);
    end

    // R10 idle low inside a frame, high after
    sendFrame(2'd0, 9'h012, 1'b0, 1'b1, -1, 1'b1);
    check(idle == 1, "R10", "idle after frame", idle, 1);
    pop();

    // R2 short low pulse is not a start bit
    rxLine = 1'b0;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check(idle == 1, "R2", "idle after glitch", idle, 1);
    check(charCount == 0, "R2", "nothing stored", charCount, 0);

    // R3 one-sample disturbance in data bits 2 and 5 is voted out
    sendFrame(2'd0, 9'h0B4, 1'b0, 1'b1, 2, 1'b0);
    sendFrame(2'd0, 9'h0B4, 1'b0, 1'b1, 5, 1'b0);
    checkHead("R3", 9'h0B4, 1'b0, 1'b0);
    pop();
    checkHead("R3", 9'h0B4, 1'b0, 1'b0);
    pop();

    // R6 pop on empty changes nothing
    pop();
    check(charCount == 0, "R6", "pop on empty", charCount, 0);

    // R6 R9: flags travel with each entry, interrupt levels
    sendFrame(2'd1, 9'h011, 1'b1, 1'b1, -1, 1'b0);  // parity error
    irqSel = 2'd0; @(negedge clk);
    check(irq == 1, "R9", "sel0 with 1", irq, 1);
    irqSel = 2'd1; @(negedge clk);
    check(irq == 0, "R9", "sel1 with 1", irq, 0);
    sendFrame(2'd1, 9'h022, 1'b0, 1'b0, -1, 1'b0);  // framing error
    sendFrame(2'd1, 9'h033, 1'b0, 1'b1, -1, 1'b0);  // clean
    check(irq == 1, "R9", "sel1 with 3", irq, 1);
    irqSel = 2'd2; @(negedge clk);
    check(irq == 0, "R9", "sel2 with 3", irq, 0);
    sendFrame(2'd1, 9'h044, 1'b1, 1'b0, -1, 1'b0);  // both errors
    check(charCount == 4, "R6", "full count", charCount, 4);
    check(irq == 1, "R9", "sel2 full", irq, 1);
    irqSel = 2'd3; @(negedge clk);
    check(irq == 1, "R9", "sel3 full", irq, 1);

    // R7 overrun on full queue
    sendFrame(2'd1, 9'h0EE, 1'b0, 1'b1, -1, 1'b0);
    check(overrun == 1, "R7", "overrun set", overrun, 1);
    check(charCount == 4, "R7", "count kept", charCount, 4);
    checkHead("R7", 9'h011, 1'b1, 1'b0);
    pop();
    checkHead("R6", 9'h022, 1'b0, 1'b1);

    // R8 frame dropped while overrun is set, room available
    sendFrame(2'd1, 9'h066, 1'b0, 1'b1, -1, 1'b0);
    check(charCount == 3, "R8", "dropped with room", charCount, 3);
    check(overrun == 1, "R7", "still set", overrun, 1);

    ovrClear = 1'b1; @(negedge clk); ovrClear = 1'b0; @(negedge clk);
    check(overrun == 0, "R7", "cleared", overrun, 0);
    sendFrame(2'd1, 9'h077, 1'b0, 1'b1, -1, 1'b0);
    check(charCount == 4, "R8", "accepted after clear", charCount, 4);

    pop();
    checkHead("R6", 9'h033, 1'b0, 1'b0);
    pop();
    checkHead("R6", 9'h044, 1'b1, 1'b1);
    pop();
    checkHead("R6", 9'h077, 1'b0, 1'b0);
    pop();
    check(rdValid == 0, "R6", "drained", rdValid, 0);
    check(irq == 0, "R9", "empty no irq", irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule